// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two threshold values that a large synchronous FIFO compares against its fill level to raise almost-empty and almost-full. One value measures distance from empty, the other distance from full. The block presents both values continuously to the flag logic, which lives outside it, together with the memory array.

A single active-low select input, `prog_n`, splits the control space in two. While `prog_n` is low, the write, read and serial enables act on the threshold values. They can be loaded in parallel from the data bus, read back onto the output bus, or shifted in one bit per clock. While `prog_n` is high, the write and read enables pass through to the memory as ordinary FIFO operations.

The level of `prog_n` during a synchronous master reset selects the default thresholds. It also selects whether the values are later loaded serially or in parallel. That choice holds until the next master reset. Readback works in either method. The behaviour is the same whether the surrounding FIFO runs in standard or first-word-fall-through mode.

Top module: `olp_offset_loader`

## Requirements
- R1: During a cycle with `mrst` high, `ser_mode` captures the inverse of `prog_n`: low selects the serial method and high selects the parallel method. `ser_mode` then keeps that value, whatever `prog_n` does, until the next master reset.
- R2: Master reset with `prog_n` low sets both thresholds to 0x07F. Master reset with `prog_n` high sets both to 0x3FF. Reset also returns both the write pointer and the readback pointer to the empty threshold, and clears `dout` and `dout_vld`.
- R3: In parallel method, a cycle with `prog_n` low and `wr_en` high stores `din[OFS_W-1:0]`. Successive writes alternate empty, full, empty and so on. The new value is visible on the threshold outputs after that clock edge.
- R4: A cycle with `prog_n` low, `rd_en` high and `wr_en` low drives the selected threshold, zero-extended, onto `dout` and sets `dout_vld` after the edge. Successive reads alternate empty, full through their own pointer, in either method. In all other cycles `dout_vld` is low and `dout` holds its value.
- R5: In serial method, a cycle with `prog_n` low, `ser_en` high and `wr_en` and `rd_en` low shifts `ser_in` into bit 2*OFS_W-1 of the chain {full, empty}, and every chain bit moves one place toward bit 0. After 2*OFS_W shifts, the first bit sent is the empty LSB and the last is the full MSB.
- R6: A parallel write made in serial method changes nothing, including the write pointer. A shift made in parallel method also changes nothing.
- R7: While `prog_n` is high and `mrst` is low, `mem_wr` follows `wr_en` and `mem_rd` follows `rd_en` in the same cycle. `ser_en` is ignored and the thresholds do not change. While `prog_n` is low or `mrst` is high, both memory strobes stay low.
- R8: With `prog_n` low and several enables high, write takes precedence over read, and read over shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; all state changes on its rising edge |
| mrst | input | 1 | Synchronous master reset, active high |
| prog_n | input | 1 | Low selects threshold programming; its level at reset picks method and defaults |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| din | input | DATA_W | Data bus; low OFS_W bits feed parallel loads |
| dout | output | DATA_W | Registered readback of a threshold |
| dout_vld | output | 1 | High for the cycle after a readback |
| empty_ofs | output | OFS_W | Current almost-empty threshold |
| full_ofs | output | OFS_W | Current almost-full threshold |
| ser_mode | output | 1 | Latched method, 1 for serial |
| mem_wr | output | 1 | Memory write strobe passed through |
| mem_rd | output | 1 | Memory read strobe passed through |

## Verification
The main decode is tried with each single enable, and with the pairs and triples of enables, on both sides of `prog_n`. This separates pass-through strobes from threshold operations and shows the write-over-read-over-shift precedence. Writes and reads are run past their wrap point, so the two pointers can be seen to advance independently. Both reset levels are applied, so the defaults and the method latch are tested at 0x07F and at 0x3FF. A 26-bit serial pattern with distinct empty and full halves shows the shift direction and the chain order, and the state after the first shift pins down the entry bit.

// File: rtl/olp_pkg.sv
package olp_pkg;
   typedef enum logic [1:0] {
      POP_NONE  = 2'd0,
      POP_WRITE = 2'd1,
      POP_READ  = 2'd2,
      POP_SHIFT = 2'd3
   } prog_op_e;
endpackage

// File: rtl/olp_decode.sv
module olp_decode
   import olp_pkg::*;
(
   input  logic     mrst,
   input  logic     prog_n,
   input  logic     wr_en,
   input  logic     rd_en,
   input  logic     ser_en,
   output prog_op_e prog_op,
   output logic     mem_wr,
   output logic     mem_rd
);
   // Priority write > read > shift while programming (R8).
   always_comb begin
      prog_op = POP_NONE;
      mem_wr  = 1'b0;
      mem_rd  = 1'b0;
      if (!mrst) begin
         if (!prog_n) begin
            if (wr_en)       prog_op = POP_WRITE;
            else if (rd_en)  prog_op = POP_READ;
            else if (ser_en) prog_op = POP_SHIFT;
         end else begin
            mem_wr = wr_en;
            mem_rd = rd_en;
         end
      end
   end
endmodule

// File: rtl/olp_regs.sv
module olp_regs
   import olp_pkg::*;
#(
   parameter int OFS_W     = 13,
   parameter int DEF_LO    = 'h07F,
   parameter int DEF_HI    = 'h3FF,
   parameter bit SERIAL_OK = 1'b1
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             prog_n,
   input  prog_op_e         prog_op,
   input  logic             ser_in,
   input  logic [OFS_W-1:0] din_ofs,
   output logic [OFS_W-1:0] empty_ofs,
   output logic [OFS_W-1:0] full_ofs,
   output logic             ser_mode
);
   localparam int CHAIN_W = 2 * OFS_W;
   localparam logic [OFS_W-1:0] LO_V = OFS_W'(DEF_LO);
   localparam logic [OFS_W-1:0] HI_V = OFS_W'(DEF_HI);

   generate
      if (OFS_W < 2) begin : g_bad_w
         $error("olp_regs: OFS_W must be at least 2");
      end
      if (DEF_LO >= (1 << OFS_W) || DEF_HI >= (1 << OFS_W)) begin : g_bad_def
         $error("olp_regs: default offsets do not fit OFS_W");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain;
   logic               wr_ptr;
   logic               mode_q;

   // Method latch: only present when serial loading is built in.
   generate
      if (SERIAL_OK) begin : g_ser
         always_ff @(posedge clk) begin
            if (mrst) mode_q <= ~prog_n;
         end
      end else begin : g_par
         assign mode_q = 1'b0;
      end
   endgenerate

   logic wr_ok, sh_ok;
   assign wr_ok = (prog_op == POP_WRITE) && !mode_q;
   assign sh_ok = (prog_op == POP_SHIFT) && mode_q;

   always_ff @(posedge clk) begin
      if (mrst) begin
         chain  <= prog_n ? {HI_V, HI_V} : {LO_V, LO_V};
         wr_ptr <= 1'b0;
      end else if (wr_ok) begin
         if (!wr_ptr) chain[OFS_W-1:0]       <= din_ofs;
         else         chain[CHAIN_W-1:OFS_W] <= din_ofs;
         wr_ptr <= ~wr_ptr;
      end else if (sh_ok) begin
         chain <= {ser_in, chain[CHAIN_W-1:1]};
      end
   end

   assign empty_ofs = chain[OFS_W-1:0];
   assign full_ofs  = chain[CHAIN_W-1:OFS_W];
   assign ser_mode  = mode_q;

   p_mode_hold_r1: assert property (@(posedge clk) disable iff (mrst)
      !$past(mrst) |-> $stable(ser_mode));
   p_default_r2: assert property (@(posedge clk) disable iff (mrst)
      $past(mrst) |-> (empty_ofs == full_ofs) &&
                      (empty_ofs == ($past(prog_n) ? HI_V : LO_V)));
   p_shift_in_r5: assert property (@(posedge clk) disable iff (mrst)
      (prog_op == POP_SHIFT && ser_mode) |=> full_ofs[OFS_W-1] == $past(ser_in));
   p_wr_ignored_r6: assert property (@(posedge clk) disable iff (mrst)
      (prog_op == POP_WRITE && ser_mode) |=> $stable(chain) && $stable(wr_ptr));
   p_sh_ignored_r6: assert property (@(posedge clk) disable iff (mrst)
      (prog_op == POP_SHIFT && !ser_mode) |=> $stable(chain));
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (mrst)
      (prog_op == POP_NONE || prog_op == POP_READ) |=> $stable(chain));
endmodule

// File: rtl/olp_readback.sv
module olp_readback
   import olp_pkg::*;
#(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              mrst,
   input  prog_op_e          prog_op,
   input  logic [OFS_W-1:0]  empty_ofs,
   input  logic [OFS_W-1:0]  full_ofs,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld
);
   logic rd_ptr;
   logic [OFS_W-1:0] sel;
   assign sel = rd_ptr ? full_ofs : empty_ofs;

   always_ff @(posedge clk) begin
      if (mrst) begin
         rd_ptr   <= 1'b0;
         dout     <= '0;
         dout_vld <= 1'b0;
      end else begin
         dout_vld <= (prog_op == POP_READ);
         if (prog_op == POP_READ) begin
            dout   <= DATA_W'(sel);
            rd_ptr <= ~rd_ptr;
         end
      end
   end

   p_rd_valid_r4: assert property (@(posedge clk) disable iff (mrst)
      (prog_op == POP_READ) |=> dout_vld && (dout[OFS_W-1:0] == $past(sel)));
   p_rd_hold_r4: assert property (@(posedge clk) disable iff (mrst)
      (prog_op != POP_READ) |=> !dout_vld && $stable(dout));
endmodule

// File: rtl/olp_offset_loader.sv
module olp_offset_loader
   import olp_pkg::*;
#(
   parameter int OFS_W     = 13,
   parameter int DATA_W    = 18,
   parameter int DEF_LO    = 'h07F,
   parameter int DEF_HI    = 'h3FF,
   parameter bit SERIAL_OK = 1'b1
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              prog_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              ser_en,
   input  logic              ser_in,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld,
   output logic [OFS_W-1:0]  empty_ofs,
   output logic [OFS_W-1:0]  full_ofs,
   output logic              ser_mode,
   output logic              mem_wr,
   output logic              mem_rd
);
   generate
      if (OFS_W >= DATA_W) begin : g_bad_bus
         $error("olp_offset_loader: OFS_W must be narrower than DATA_W");
      end else begin : g_hi_bits
         logic unused_din_hi;
         assign unused_din_hi = ^din[DATA_W-1:OFS_W];
      end
   endgenerate

   prog_op_e prog_op;

   olp_decode u_dec (
      .mrst    (mrst),
      .prog_n  (prog_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .ser_en  (ser_en),
      .prog_op (prog_op),
      .mem_wr  (mem_wr),
      .mem_rd  (mem_rd)
   );

   olp_regs #(
      .OFS_W     (OFS_W),
      .DEF_LO    (DEF_LO),
      .DEF_HI    (DEF_HI),
      .SERIAL_OK (SERIAL_OK)
   ) u_regs (
      .clk       (clk),
      .mrst      (mrst),
      .prog_n    (prog_n),
      .prog_op   (prog_op),
      .ser_in    (ser_in),
      .din_ofs   (din[OFS_W-1:0]),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .ser_mode  (ser_mode)
   );

   olp_readback #(
      .OFS_W  (OFS_W),
      .DATA_W (DATA_W)
   ) u_rb (
      .clk       (clk),
      .mrst      (mrst),
      .prog_op   (prog_op),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .dout      (dout),
      .dout_vld  (dout_vld)
   );

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (mrst)
      (mem_wr || mem_rd) |-> (prog_op == POP_NONE) && prog_n);
   p_prio_r8: assert property (@(posedge clk) disable iff (mrst)
      (!prog_n && wr_en && (rd_en || ser_en)) |=> !dout_vld);
endmodule

// File: tb/sim_olp_offset_loader.sv
module sim_olp_offset_loader;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        mrst, prog_n, wr_en, rd_en, ser_en, ser_in;
   logic [17:0] din, dout;
   logic        dout_vld, ser_mode, mem_wr, mem_rd;
   logic [12:0] empty_ofs, full_ofs;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   olp_offset_loader u0 (
      .clk(clk), .mrst(mrst), .prog_n(prog_n), .wr_en(wr_en), .rd_en(rd_en),
      .ser_en(ser_en), .ser_in(ser_in), .din(din), .dout(dout),
      .dout_vld(dout_vld), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
      .ser_mode(ser_mode), .mem_wr(mem_wr), .mem_rd(mem_rd));

   typedef struct packed {
      logic [3:0]  ctl;   // {prog_n, wr_en, rd_en, ser_en}
      logic [12:0] d;
      logic [12:0] e;
      logic [12:0] f;
      logic        vld;
      logic [12:0] q;
      logic        mw;
      logic        mr;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{4'b1100, 13'h0000, 13'h03FF, 13'h03FF, 1'b0, 13'h0000, 1'b1, 1'b0},
      '{4'b1010, 13'h0000, 13'h03FF, 13'h03FF, 1'b0, 13'h0000, 1'b0, 1'b1},
      '{4'b1111, 13'h0000, 13'h03FF, 13'h03FF, 1'b0, 13'h0000, 1'b1, 1'b1},
      '{4'b0100, 13'h0123, 13'h0123, 13'h03FF, 1'b0, 13'h0000, 1'b0, 1'b0},
      '{4'b0100, 13'h1ABC, 13'h0123, 13'h1ABC, 1'b0, 13'h0000, 1'b0, 1'b0},
      '{4'b0010, 13'h0000, 13'h0123, 13'h1ABC, 1'b1, 13'h0123, 1'b0, 1'b0},
      '{4'b0001, 13'h0000, 13'h0123, 13'h1ABC, 1'b0, 13'h0123, 1'b0, 1'b0},
      '{4'b0010, 13'h0000, 13'h0123, 13'h1ABC, 1'b1, 13'h1ABC, 1'b0, 1'b0},
      '{4'b0100, 13'h0055, 13'h0055, 13'h1ABC, 1'b0, 13'h1ABC, 1'b0, 1'b0},
      '{4'b0110, 13'h1FFF, 13'h0055, 13'h1FFF, 1'b0, 13'h1ABC, 1'b0, 1'b0},
      '{4'b0010, 13'h0000, 13'h0055, 13'h1FFF, 1'b1, 13'h0055, 1'b0, 1'b0},
      '{4'b0000, 13'h0000, 13'h0055, 13'h1FFF, 1'b0, 13'h0055, 1'b0, 1'b0},
      '{4'b1001, 13'h0000, 13'h0055, 13'h1FFF, 1'b0, 13'h0055, 1'b0, 1'b0}
   };

   localparam logic [25:0] PAT = {13'h0ACE, 13'h1234};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] c, input logic [12:0] d, input logic s);
      {prog_n, wr_en, rd_en, ser_en} = c;
      din    = {5'b0, d};
      ser_in = s;
   endtask

   task automatic do_reset(input logic lvl);
      @(negedge clk);
      mrst = 1'b1;
      drive({lvl, 3'b111}, 13'h1FFF, 1'b1);
      #1;
      chk("R7 strobes low in reset", {mem_wr, mem_rd}, 2'b00);
      @(posedge clk); #1;
      @(negedge clk);
      mrst = 1'b0;
      drive({lvl, 3'b000}, 13'h0000, 1'b0);
   endtask

   initial begin
      mrst = 1'b1;
      drive(4'b1000, 13'h0, 1'b0);

      // R2 R1: parallel method, high defaults
      do_reset(1'b1);
      #1;
      chk("R1 method parallel", ser_mode, 1'b0);
      chk("R2 empty default hi", empty_ofs, 13'h03FF);
      chk("R2 full default hi", full_ofs, 13'h03FF);
      chk("R2 dout_vld cleared", dout_vld, 1'b0);

      // Table: R3 R4 R6 R7 R8 in parallel method
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(TBL[i].ctl, TBL[i].d, 1'b1);
         #1;
         chk($sformatf("R7 mem_wr row %0d", i), mem_wr, TBL[i].mw);
         chk($sformatf("R7 mem_rd row %0d", i), mem_rd, TBL[i].mr);
         @(posedge clk); #1;
         chk($sformatf("R3 R6 empty row %0d", i), empty_ofs, TBL[i].e);
         chk($sformatf("R3 R8 full row %0d", i), full_ofs, TBL[i].f);
         chk($sformatf("R4 vld row %0d", i), dout_vld, TBL[i].vld);
         chk($sformatf("R4 dout row %0d", i), dout, {5'b0, TBL[i].q});
      end

      // Serial method, low defaults
      do_reset(1'b0);
      #1;
      chk("R1 method serial", ser_mode, 1'b1);
      chk("R2 empty default lo", empty_ofs, 13'h007F);
      chk("R2 full default lo", full_ofs, 13'h007F);

      // R6: parallel write ignored in serial method
      @(negedge clk); drive(4'b0100, 13'h0AAA, 1'b0);
      @(posedge clk); #1;
      chk("R6 write ignored empty", empty_ofs, 13'h007F);
      chk("R6 write ignored full", full_ofs, 13'h007F);

      // R4: readback works in serial method
      @(negedge clk); drive(4'b0010, 13'h0, 1'b0);
      @(posedge clk); #1;
      chk("R4 serial-mode read vld", dout_vld, 1'b1);
      chk("R4 serial-mode read dout", dout, 18'h0007F);

      // R5: shift in 26 bits, empty LSB first
      for (int i = 0; i < 26; i++) begin
         @(negedge clk); drive(4'b0001, 13'h0, PAT[i]);
         @(posedge clk); #1;
         if (i == 0) begin
            chk("R5 first shift full", full_ofs, {PAT[0], 12'h03F});
            chk("R5 first shift empty", empty_ofs, 13'h103F);
         end
      end
      chk("R5 chain empty", empty_ofs, 13'h1234);
      chk("R5 chain full", full_ofs, 13'h0ACE);

      // R8: read beats shift; second read takes full
      @(negedge clk); drive(4'b0011, 13'h0, 1'b1);
      @(posedge clk); #1;
      chk("R8 read over shift vld", dout_vld, 1'b1);
      chk("R8 read over shift dout", dout, 18'h00ACE);
      chk("R8 no shift happened", full_ofs, 13'h0ACE);

      // R1 R7: prog_n high with ser_en, method held
      @(negedge clk); drive(4'b1101, 13'h0, 1'b0);
      #1;
      chk("R7 pass-through write", mem_wr, 1'b1);
      @(posedge clk); #1;
      chk("R1 method held", ser_mode, 1'b1);
      chk("R7 ser_en ignored empty", empty_ofs, 13'h1234);
      chk("R7 ser_en ignored full", full_ofs, 13'h0ACE);

      @(negedge clk); drive(4'b0000, 13'h0, 1'b0);
      @(posedge clk); #1;
      chk("R4 vld drops", dout_vld, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule